// File: doc/BRIEF.md
# Authenticated Flash Command Frame Validator

This block sits on the device side of a serial flash link that carries one data bit per clock in each direction. It watches each chip-select frame. When the first byte of a frame is the replay-protection command opcode, it collects the bytes that follow: the command type, then the counter address, then the rest of the payload. It also counts how many bytes arrive. When chip-select rises, it compares the frame length with the length that the command type needs. Frames that pass are handed to a downstream command executor. Frames that fail are answered with a format error code in the extended status byte.

An early busy flag is raised as soon as the opcode byte is complete. The flag stays up until the executor reports that it has finished. The executor returns the semantic error flags (signature, counter-state and counter-data checks). This block folds those flags into the extended status byte. Only a frame whose length was correct can reach the executor, so the semantic bits can never appear together with a length failure. Signature computation, counter storage and array programming all belong to the executor.

Top module: `afv_frame_check`

## Requirements
- R1: Serial bits are assembled most significant bit first. Byte 0 of a frame is the opcode, byte 1 is the command type and byte 2 is the counter address. For an accepted frame, `cmd_type_o` and `cnt_addr_o` carry bytes 1 and 2 during the `frame_vld_o` cycle.
- R2: When an opcode byte equal to `OP1_CODE` (default 9Bh) completes as byte 0 of a frame, `xst_o` becomes 01h and `busy_o` rises on the clock after the last opcode bit. A frame with any other first byte has no effect.
- R3: `xst_o` is 00h after reset. It keeps its value until an accepted opcode byte completes, a frame is rejected, or an execution finishes.
- R4: At the rise of chip-select, the frame length counts the opcode byte. The length must be 64 bytes for type 00h, 40 bytes for types 01h and 02h, and 48 bytes for type 03h. A wrong byte count, or a frame that ends inside a byte, sets `xst_o` to 04h and clears `busy_o`. No `frame_vld_o` is raised in that case.
- R5: A command type from 04h to FFh sets `xst_o` to 04h at the rise of chip-select, whatever the frame length.
- R6: A frame that passes R4 and R5 raises `frame_vld_o` for exactly one cycle, on the clock after chip-select rises. `busy_o` then stays high until `exec_done_i`.
- R7: Every byte of an accepted frame from the counter address onward appears on `pay_byte_o`, with a one-cycle `pay_vld_o`, on the clock after its last bit.
- R8: While a command is executing, `exec_done_i` with `exec_err_i` = 0 sets `xst_o` to 80h. With a non-zero `exec_err_i`, the status bits map as follows: bit 1 = err[0], bit 2 = err[1], bit 3 = err[2], bit 4 = err[3], and all other bits are 0. `busy_o` clears in both cases. An `exec_done_i` pulse outside execution is ignored.
- R9: `xst_o` bits 1, 3 and 4 are only ever set by a completed execution. They are never set by a length or type rejection.
- R10: If `dpd_i` (deep power-down) or `susp_i` (suspended) is high when the opcode byte completes, the frame is ignored: `xst_o` and `busy_o` do not change.
- R11: A frame whose opcode byte completes while an earlier command is still executing is ignored in full. This holds even when `exec_done_i` arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low; a frame ends when it rises |
| bit_en_i | input | 1 | Marks a cycle that carries one serial data bit |
| sdi_i | input | 1 | Serial data in |
| dpd_i | input | 1 | Device is in deep power-down |
| susp_i | input | 1 | Device is suspended |
| exec_done_i | input | 1 | Executor has finished the handed-off command |
| exec_err_i | input | 4 | Executor error flags, valid with exec_done_i |
| busy_o | output | 1 | A command is being received or executed |
| xst_o | output | 8 | Extended status byte |
| frame_vld_o | output | 1 | One-cycle strobe for an accepted frame |
| cmd_type_o | output | 8 | Command type of the accepted frame |
| cnt_addr_o | output | 8 | Counter address of the accepted frame |
| pay_vld_o | output | 1 | Payload byte strobe |
| pay_byte_o | output | 8 | Payload byte |

## Verification
Two events can land on the same clock edge: the completion of a new opcode byte and the executor's done pulse for the previous command. The bench provokes this by driving `exec_done_i` on the last bit of a second, otherwise valid opcode while the first command is still executing. The expected result is as follows. The status takes the completion code and the busy flag drops. The second frame leaves no trace: there is no busy, no format error and no strobe when its chip-select rises. A behavioural model, built from bit counts and byte indices, predicts every output on every clock and is compared with the design. Directed frames cover each type at its correct length, frames one byte short, frames with trailing extra bits, reserved types, power-down and suspend.

// File: rtl/afv_pkg.sv
package afv_pkg;
  localparam int BYTE_W = 8;
  localparam int XST_W  = 8;

  localparam logic [XST_W-1:0] XST_BUSY = 8'h01;
  localparam logic [XST_W-1:0] XST_FMT  = 8'h04;
  localparam logic [XST_W-1:0] XST_OK   = 8'h80;
  localparam logic [XST_W-1:0] XST_SEM  = 8'h1A;  // bits only an execution may set

  localparam logic [BYTE_W-1:0] TYPE_LIMIT = 8'h04;

  localparam int LEN_ROOT = 64;
  localparam int LEN_KEY  = 40;
  localparam int LEN_INC  = 40;
  localparam int LEN_REQ  = 48;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_CAPT,
    FS_SKIP,
    FS_EXEC
  } fstate_e;

  function automatic int req_len(input logic [BYTE_W-1:0] t);
    case (t)
      8'h00:   return LEN_ROOT;
      8'h01:   return LEN_KEY;
      8'h02:   return LEN_INC;
      8'h03:   return LEN_REQ;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/afv_shift.sv
module afv_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          bit_en_i,
  input  logic          sdi_i,
  output logic          byte_vld_o,
  output logic [BW-1:0] byte_o,
  output logic          partial_o
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [CW-1:0] bit_cnt_q;
  logic [BW-2:0] sh_q;
  logic          take;

  assign take = bit_en_i & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      sh_q      <= '0;
    end else if (cs_ni) begin
      bit_cnt_q <= '0;
    end else if (take) begin
      bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
      sh_q      <= {sh_q[BW-3:0], sdi_i};
    end
  end

  // byte completes in the same cycle as its final bit
  assign byte_vld_o = take && (bit_cnt_q == LAST);
  assign byte_o     = {sh_q, sdi_i};
  assign partial_o  = (bit_cnt_q != '0);

  AST_BITS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_cnt_q == '0)); // R4
endmodule

// File: rtl/afv_track.sv
module afv_track
  import afv_pkg::*;
#(
  parameter int               CNT_W    = 7,
  parameter logic [BYTE_W-1:0] OP1_CODE = 8'h9B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              partial_i,
  input  logic              dpd_i,
  input  logic              susp_i,
  input  logic              exec_done_i,
  output logic              open_o,
  output logic              bad_o,
  output logic              fin_o,
  output logic              busy_o,
  output logic              frame_vld_o,
  output logic [BYTE_W-1:0] cmd_type_o,
  output logic [BYTE_W-1:0] cnt_addr_o,
  output logic              pay_vld_o,
  output logic [BYTE_W-1:0] pay_byte_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] IDX_TYPE = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_ADDR = CNT_W'(2);

  fstate_e           state_q;
  logic              cs_q;
  logic              cs_rise;
  logic [CNT_W-1:0]  byte_cnt_q;
  logic [BYTE_W-1:0] type_q;
  logic [BYTE_W-1:0] addr_q;
  logic              fv_q;
  logic              pv_q;
  logic [BYTE_W-1:0] pb_q;
  logic              first_byte;
  logic              accept;
  logic              len_ok;
  logic              frame_ok;

  assign cs_rise    = cs_ni & ~cs_q;
  assign first_byte = byte_vld_i && (byte_cnt_q == '0);
  assign accept     = (byte_i == OP1_CODE) && !dpd_i && !susp_i;
  assign len_ok     = (int'(byte_cnt_q) == req_len(type_q));
  assign frame_ok   = !partial_i && (type_q < TYPE_LIMIT) && len_ok;

  assign open_o = (state_q == FS_IDLE) && first_byte && accept;
  assign bad_o  = (state_q == FS_CAPT) && cs_rise && !frame_ok;
  assign fin_o  = (state_q == FS_EXEC) && exec_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      byte_cnt_q <= '0;
    end else begin
      cs_q <= cs_ni;
      if (cs_ni)
        byte_cnt_q <= '0;
      else if (byte_vld_i && byte_cnt_q != CNT_MAX)
        byte_cnt_q <= byte_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      type_q  <= '0;
      addr_q  <= '0;
      fv_q    <= 1'b0;
      pv_q    <= 1'b0;
      pb_q    <= '0;
    end else begin
      fv_q <= 1'b0;
      pv_q <= 1'b0;
      unique case (state_q)
        FS_IDLE: begin
          if (first_byte) begin
            if (accept) begin
              state_q <= FS_CAPT;
              type_q  <= '0;
              addr_q  <= '0;
            end else begin
              state_q <= FS_SKIP;
            end
          end
        end
        FS_CAPT: begin
          if (cs_rise) begin
            if (frame_ok) begin
              fv_q    <= 1'b1;
              state_q <= FS_EXEC;
            end else begin
              state_q <= FS_IDLE;
            end
          end else if (byte_vld_i) begin
            if (byte_cnt_q == IDX_TYPE) type_q <= byte_i;
            if (byte_cnt_q == IDX_ADDR) addr_q <= byte_i;
            if (byte_cnt_q >= IDX_ADDR) begin
              pv_q <= 1'b1;
              pb_q <= byte_i;
            end
          end
        end
        FS_SKIP: begin
          if (cs_rise) state_q <= FS_IDLE;
        end
        FS_EXEC: begin
          if (exec_done_i) state_q <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q == FS_CAPT) || (state_q == FS_EXEC);
  assign frame_vld_o = fv_q;
  assign cmd_type_o  = type_q;
  assign cnt_addr_o  = addr_q;
  assign pay_vld_o   = pv_q;
  assign pay_byte_o  = pb_q;

  AST_FV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o); // R6
  AST_EXEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_EXEC && !exec_done_i) |=> busy_o); // R6
  AST_PAY_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_o |-> $past(state_q == FS_CAPT)); // R7
  AST_EXEC_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_EXEC && byte_vld_i) |-> !open_o); // R11
endmodule

// File: rtl/afv_xst.sv
module afv_xst
  import afv_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             bad_i,
  input  logic             fin_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [XST_W-1:0] xst_o
);
  logic [XST_W-1:0] xst_q;
  logic [XST_W-1:0] err_code;

  // error flag k lands on status bit k+1
  always_comb begin
    err_code = '0;
    for (int k = 0; k < ERR_W; k++) err_code[k+1] = err_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      xst_q <= '0;
    else if (open_i)
      xst_q <= XST_BUSY;
    else if (bad_i)
      xst_q <= XST_FMT;
    else if (fin_i)
      xst_q <= (err_i == '0) ? XST_OK : err_code;
  end

  assign xst_o = xst_q;

  AST_SEM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((xst_q & XST_SEM) != '0) && !$stable(xst_q)) |-> $past(fin_i)); // R9
  AST_XST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(open_i) && !$past(bad_i) && !$past(fin_i)) |-> $stable(xst_q)); // R3
  AST_FMT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> (xst_q == XST_FMT)); // R4
endmodule

// File: rtl/afv_frame_check.sv
module afv_frame_check
  import afv_pkg::*;
#(
  parameter logic [7:0] OP1_CODE = 8'h9B,
  parameter int         CNT_W    = 7,
  parameter int         ERR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             bit_en_i,
  input  logic             sdi_i,
  input  logic             dpd_i,
  input  logic             susp_i,
  input  logic             exec_done_i,
  input  logic [ERR_W-1:0] exec_err_i,
  output logic             busy_o,
  output logic [7:0]       xst_o,
  output logic             frame_vld_o,
  output logic [7:0]       cmd_type_o,
  output logic [7:0]       cnt_addr_o,
  output logic             pay_vld_o,
  output logic [7:0]       pay_byte_o
);
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_d;
  logic              partial;
  logic              ev_open;
  logic              ev_bad;
  logic              ev_fin;

  afv_shift #(.BW(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .bit_en_i  (bit_en_i),
    .sdi_i     (sdi_i),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_d),
    .partial_o (partial)
  );

  afv_track #(.CNT_W(CNT_W), .OP1_CODE(OP1_CODE)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .partial_i  (partial),
    .dpd_i      (dpd_i),
    .susp_i     (susp_i),
    .exec_done_i(exec_done_i),
    .open_o     (ev_open),
    .bad_o      (ev_bad),
    .fin_o      (ev_fin),
    .busy_o     (busy_o),
    .frame_vld_o(frame_vld_o),
    .cmd_type_o (cmd_type_o),
    .cnt_addr_o (cnt_addr_o),
    .pay_vld_o  (pay_vld_o),
    .pay_byte_o (pay_byte_o)
  );

  afv_xst #(.ERR_W(ERR_W)) u_xst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .open_i(ev_open),
    .bad_i (ev_bad),
    .fin_i (ev_fin),
    .err_i (exec_err_i),
    .xst_o (xst_o)
  );

  AST_BUSY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == xst_o[0]); // R2
  AST_OPEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_open |=> (busy_o && xst_o == XST_BUSY)); // R2
  AST_LOWPWR_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dpd_i || susp_i) |-> !ev_open); // R10
endmodule

// File: tb/afv_frame_check_bench.sv
module afv_frame_check_bench;
  typedef logic [7:0] bq_t[$];

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, bit_en_i = 1'b0, sdi_i = 1'b0;
  logic       dpd_i = 1'b0, susp_i = 1'b0, exec_done_i = 1'b0;
  logic [3:0] exec_err_i = '0;
  logic       busy_o, frame_vld_o, pay_vld_o;
  logic [7:0] xst_o, cmd_type_o, cnt_addr_o, pay_byte_o;

  always #2 clk_i = ~clk_i;

  afv_frame_check u_afv_frame_check (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .bit_en_i(bit_en_i), .sdi_i(sdi_i),
    .dpd_i(dpd_i), .susp_i(susp_i), .exec_done_i(exec_done_i), .exec_err_i(exec_err_i),
    .busy_o(busy_o), .xst_o(xst_o), .frame_vld_o(frame_vld_o), .cmd_type_o(cmd_type_o),
    .cnt_addr_o(cnt_addr_o), .pay_vld_o(pay_vld_o), .pay_byte_o(pay_byte_o)
  );

  int checks = 0, errors = 0;
  int n_fv = 0, n_pv = 0;
  logic [7:0] last_type, last_addr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [7:0] t);
    if (t == 8'h00) return 64;
    if (t == 8'h01 || t == 8'h02) return 40;
    if (t == 8'h03) return 48;
    return -1;
  endfunction

  // behavioural model: 0 idle, 1 capturing, 2 skipping, 3 executing
  int m_mode, m_nbits;
  logic [7:0] m_cur, m_type, m_addr, m_xst, m_pbyte;
  bit m_fv, m_pv, m_csp;

  always @(posedge clk_i) begin
    int om, idx;
    if (!rst_ni) begin
      m_mode = 0; m_nbits = 0; m_cur = 0; m_type = 0; m_addr = 0;
      m_xst = 0; m_pbyte = 0; m_fv = 0; m_pv = 0; m_csp = 1;
    end else begin
      om = m_mode; m_fv = 0; m_pv = 0;
      if (cs_ni) begin
        if (!m_csp) begin
          if (om == 1) begin
            if ((m_nbits % 8) != 0 || m_nbits / 8 != ref_len(m_type)) begin
              m_xst = 8'h04; m_mode = 0;
            end else begin
              m_fv = 1; m_mode = 3;
            end
          end else if (om == 2) m_mode = 0;
        end
        m_nbits = 0;
      end else if (bit_en_i) begin
        m_cur = {m_cur[6:0], sdi_i};
        m_nbits++;
        if (m_nbits % 8 == 0) begin
          idx = m_nbits / 8 - 1;
          if (om == 0 && idx == 0) begin
            if (m_cur == 8'h9B && !dpd_i && !susp_i) begin
              m_mode = 1; m_xst = 8'h01; m_type = 0; m_addr = 0;
            end else m_mode = 2;
          end else if (om == 1) begin
            if (idx == 1) m_type = m_cur;
            if (idx == 2) m_addr = m_cur;
            if (idx >= 2) begin m_pv = 1; m_pbyte = m_cur; end
          end
        end
      end
      if (om == 3 && exec_done_i) begin
        m_mode = 0;
        m_xst = (exec_err_i == 0) ? 8'h80 : {3'b000, exec_err_i, 1'b0};
      end
      m_csp = cs_ni;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R3 R8 xst_o vs model", xst_o, m_xst);
      chk("R2 busy_o vs model", busy_o, (m_mode == 1 || m_mode == 3));
      chk("R6 frame_vld_o vs model", frame_vld_o, m_fv);
      chk("R7 pay_vld_o vs model", pay_vld_o, m_pv);
      if (m_fv) begin
        chk("R1 cmd_type_o", cmd_type_o, m_type);
        chk("R1 cnt_addr_o", cnt_addr_o, m_addr);
      end
      if (m_pv) chk("R7 pay_byte_o", pay_byte_o, m_pbyte);
      if (frame_vld_o) begin n_fv++; last_type = cmd_type_o; last_addr = cnt_addr_o; end
      if (pay_vld_o) n_pv++;
    end
  end

  function automatic bq_t mk(input logic [7:0] op, input logic [7:0] t,
                             input logic [7:0] a, input int len);
    bq_t q;
    for (int i = 0; i < len; i++)
      q.push_back(i == 0 ? op : i == 1 ? t : i == 2 ? a : i == 3 ? 8'h00 : 8'(i * 7 + 3));
    return q;
  endfunction

  task automatic frm(input bq_t q, input int xbits, input int done_bit);
    int nb;
    nb = 0;
    @(negedge clk_i); cs_ni = 1'b0;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk_i);
        bit_en_i = 1'b1; sdi_i = q[i][b]; exec_done_i = (nb == done_bit);
        nb++;
      end
    end
    for (int k = 0; k < xbits; k++) begin
      @(negedge clk_i); bit_en_i = 1'b1; sdi_i = k[0]; exec_done_i = 1'b0;
    end
    @(negedge clk_i); bit_en_i = 1'b0; exec_done_i = 1'b0; cs_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic done(input logic [3:0] e);
    @(negedge clk_i); exec_done_i = 1'b1; exec_err_i = e;
    @(negedge clk_i); exec_done_i = 1'b0; exec_err_i = '0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0, p0;
    repeat (4) @(negedge clk_i);
    chk("R3 reset xst_o", xst_o, 8'h00);
    chk("R3 reset busy_o", busy_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R3: foreign opcode is ignored
    frm(mk(8'h03, 8'h02, 8'h01, 40), 0, -1);
    chk("R2 foreign opcode xst", xst_o, 8'h00);
    chk("R2 foreign opcode busy", busy_o, 1'b0);

    // R1 R6 R7 R8: valid increment-type frame
    f0 = n_fv; p0 = n_pv;
    frm(mk(8'h9B, 8'h02, 8'h01, 40), 0, -1);
    chk("R6 one strobe", n_fv - f0, 1);
    chk("R1 type captured", last_type, 8'h02);
    chk("R1 addr captured", last_addr, 8'h01);
    chk("R7 payload byte count", n_pv - p0, 38);
    chk("R6 busy held", busy_o, 1'b1);
    chk("R2 busy code", xst_o, 8'h01);
    done(4'h0);
    chk("R8 success code", xst_o, 8'h80);
    chk("R8 busy cleared", busy_o, 1'b0);

    // R8: done while idle is ignored
    done(4'hF);
    chk("R8 idle done ignored", xst_o, 8'h80);

    // R4: type 00h one byte short, then correct
    frm(mk(8'h9B, 8'h00, 8'h00, 63), 0, -1);
    chk("R4 type00 short", xst_o, 8'h04);
    chk("R4 busy cleared", busy_o, 1'b0);
    frm(mk(8'h9B, 8'h00, 8'h02, 64), 0, -1);
    chk("R4 type00 accepted", busy_o, 1'b1);
    done(4'h1);
    chk("R8 R9 err0 to bit1", xst_o, 8'h02);

    // R4: type 02h with type-03h length
    frm(mk(8'h9B, 8'h02, 8'h00, 48), 0, -1);
    chk("R4 per-type length", xst_o, 8'h04);

    // R6 R8: request type, error mapping
    f0 = n_fv;
    frm(mk(8'h9B, 8'h03, 8'h03, 48), 0, -1);
    chk("R6 type03 strobe", n_fv - f0, 1);
    chk("R1 type03 addr", last_addr, 8'h03);
    done(4'h8);
    chk("R8 err3 to bit4", xst_o, 8'h10);

    // R4: trailing partial byte
    frm(mk(8'h9B, 8'h01, 8'h00, 40), 3, -1);
    chk("R4 partial byte", xst_o, 8'h04);

    // R5: reserved types
    frm(mk(8'h9B, 8'h01, 8'h00, 40), 0, -1);
    done(4'h6);
    chk("R8 err1 err2 to bits 2 3", xst_o, 8'h0C);
    frm(mk(8'h9B, 8'h05, 8'h00, 40), 0, -1);
    chk("R5 type05", xst_o, 8'h04);
    frm(mk(8'h9B, 8'h00, 8'h00, 64), 0, -1);
    done(4'h0);
    frm(mk(8'h9B, 8'hFF, 8'h00, 64), 0, -1);
    chk("R5 typeFF", xst_o, 8'h04);
    chk("R9 no semantic bits", xst_o & 8'h1A, 8'h00);

    // R4: opcode only
    frm(mk(8'h9B, 8'h00, 8'h00, 1), 0, -1);
    chk("R4 opcode only", xst_o, 8'h04);

    // R10: deep power-down and suspend
    dpd_i = 1'b1;
    frm(mk(8'h9B, 8'h02, 8'h00, 40), 0, -1);
    chk("R10 dpd xst", xst_o, 8'h04);
    chk("R10 dpd busy", busy_o, 1'b0);
    dpd_i = 1'b0; susp_i = 1'b1;
    frm(mk(8'h9B, 8'h02, 8'h00, 40), 0, -1);
    chk("R10 suspend xst", xst_o, 8'h04);
    susp_i = 1'b0;

    // R11: new opcode completes in the same cycle as exec done
    frm(mk(8'h9B, 8'h01, 8'h05, 40), 0, -1);
    chk("R11 first frame executing", busy_o, 1'b1);
    f0 = n_fv;
    frm(mk(8'h9B, 8'h02, 8'h01, 40), 0, 7);
    chk("R11 completion code", xst_o, 8'h80);
    chk("R11 busy cleared", busy_o, 1'b0);
    chk("R11 no second strobe", n_fv - f0, 0);

    repeat (4) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule